// File: doc/BRIEF.md
# Clock Mode and Power-Down Controller

This block decides how fast the bus and processor clocks of a small system-on-chip run, and when they stop. Software picks one of four run speeds by writing a 3-bit speed code. The block turns that code into a power-of-two divide ratio. It issues one clock-enable pulse per divided period for each clock domain, so the clock cells downstream only gate on that pulse.

Two low-power states can be requested. In the light state the first bus domain and the processor stop, the second bus domain keeps its rate, and external SDRAM is asked to self-refresh. In the deep state every enable except the real-time one drops and both PLLs are powered down. An interrupt (IRQ or FIQ) or a watchdog reset wakes the block. Leaving the deep state passes through a settling phase. During that phase the PLL outputs stay masked for a fixed number of ticks of the 32.768 kHz reference, and then the clocks are released. The reference arrives as a one-cycle tick that is already synchronous to the main clock.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After the power-on reset is released, the block is in run operation at divide-by-8: `div_sel` = 3, and the bus and processor enables pulse once every 8 cycles.
- R2: A write with `wr_addr` = 0 loads `wr_data[2:0]` as the speed code. Codes 0, 1, 2 and 3 select `div_sel` 0, 1, 2 and 3, which divide by 1, 2, 4 and 8. Codes 4 to 7 select `div_sel` = 3. Writes to any other address have no effect.
- R3: A free-running 3-bit phase counter wraps from 7 to 0. `div_sel` changes only on the cycle in which that counter wraps. The enable pulse is high whenever the low `div_sel` bits of the counter are all ones.
- R4: In the light state, `bus1_ce` and `cpu_ce` are 0 and `bus2_ce` keeps pulsing at the run rate. `usb_en`, `lcd_en` and `rtc_en` stay 1, and `sdram_sr_req` is 1.
- R5: In the deep state, `rtc_en` is the only enable still at 1. Every bit of `pll_pd` is 1, and `pll_mask` and `sdram_sr_req` are 1. A deep request has priority over a light request in the same cycle.
- R6: IRQ, FIQ or the watchdog reset moves the light state straight to run operation. The same events move the deep state to the settling phase.
- R7: In the settling phase, `pll_pd` is 0 and `pll_mask` and `mask_busy` are 1. All enables except `rtc_en` stay low for MASK_TICKS reference ticks, and then run operation resumes. The tick count starts from zero on every deep entry.
- R8: On wake, the speed code held before entry still applies. A watchdog reset forces the speed code to 3, and it wins over a write in the same cycle.
- R9: Interrupts in run operation have no effect. Light or deep requests made in any state other than run operation are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate main clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| sleep_req | input | 1 | Light low-power request |
| suspend_req | input | 1 | Deep low-power request |
| irq | input | 1 | Normal interrupt line |
| fiq | input | 1 | Fast interrupt line |
| wdt_rst | input | 1 | Watchdog reset event |
| ref_tick | input | 1 | One-cycle tick per 32.768 kHz reference period |
| bus1_ce | output | 1 | Enable pulse for bus domain 1 |
| bus2_ce | output | 1 | Enable pulse for bus domain 2 |
| cpu_ce | output | 1 | Enable pulse for the processor clock |
| rtc_en | output | 1 | Real-time clock enable |
| usb_en | output | 1 | USB clock enable |
| lcd_en | output | 1 | LCD clock enable |
| div_sel | output | DIV_W | Active divide exponent (ratio is 2^div_sel) |
| pll_pd | output | NUM_PLL | PLL power-down, one bit per PLL |
| pll_mask | output | 1 | PLL outputs masked |
| sdram_sr_req | output | 1 | SDRAM self-refresh request |
| mask_busy | output | 1 | Settling count in progress |

## Verification
The hardest condition to reach from the ports is the exit from the settling phase. It needs a full deep entry, a wake, and thousands of reference ticks before the count expires. A second deep entry is then needed to show that the count starts again from zero rather than carrying over. The stimulus generates a periodic reference tick and runs two complete deep cycles, one woken by FIQ and one by the watchdog. A behavioural model compares every output on every cycle, so the exact release cycle is checked. Speed writes land at arbitrary phase positions, which exercises the switch at the wrap boundary.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_SLEEP = 2'd1,
    PS_SUSP  = 2'd2,
    PS_MASK  = 2'd3
  } pwr_state_e;

  localparam int unsigned SLOW_CODE = 3;

endpackage

// File: rtl/pwr_speed_reg.sv
module pwr_speed_reg #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned DIV_W  = 2
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wdt_rst,
  output logic [DIV_W-1:0]  target_div
);
  localparam int unsigned MAX_DIV = (1 << DIV_W) - 1;

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic             sel_we;

  always_comb begin
    sel_we = 1'b0;
    sel_d  = sel_q;
    if (wdt_rst) begin
      sel_we = 1'b1;
      sel_d  = SEL_W'(pwr_pkg::SLOW_CODE);
    end else if (wr_en && (wr_addr == '0)) begin
      sel_we = 1'b1;
      sel_d  = wr_data[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sel_q <= SEL_W'(pwr_pkg::SLOW_CODE);
    end else if (sel_we) begin
      sel_q <= sel_d;
    end
  end

  always_comb begin
    if (sel_q > SEL_W'(MAX_DIV)) begin
      target_div = DIV_W'(MAX_DIV);
    end else begin
      target_div = sel_q[DIV_W-1:0];
    end
  end
endmodule

// File: rtl/pwr_div_gen.sv
module pwr_div_gen #(
  parameter int unsigned DIV_W   = 2,
  parameter int unsigned PHASE_W = (1 << DIV_W) - 1
) (
  input  logic               clk,
  input  logic               srst_n,
  input  logic [DIV_W-1:0]   target_div,
  output logic [DIV_W-1:0]   div_sel,
  output logic [PHASE_W-1:0] phase,
  output logic               bus_ce
);
  logic [PHASE_W-1:0] phase_d;
  logic               wrap;
  logic [PHASE_W-1:0] sel_mask;

  always_comb begin
    wrap     = (phase == '1);
    phase_d  = phase + PHASE_W'(1);
    sel_mask = ~({PHASE_W{1'b1}} << div_sel);
    bus_ce   = ((phase & sel_mask) == sel_mask);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase <= '0;
    end else begin
      phase <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      div_sel <= DIV_W'(pwr_pkg::SLOW_CODE);
    end else if (wrap) begin
      div_sel <= target_div;
    end
  end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm #(
  parameter int unsigned MASK_TICKS = 3280,
  parameter int unsigned MCNT_W     = $clog2(MASK_TICKS)
) (
  input  logic                clk,
  input  logic                srst_n,
  input  logic                sleep_req,
  input  logic                suspend_req,
  input  logic                wake,
  input  logic                ref_tick,
  output pwr_pkg::pwr_state_e state
);
  import pwr_pkg::*;

  pwr_state_e          state_d;
  logic [MCNT_W-1:0]   mcnt_q;
  logic [MCNT_W-1:0]   mcnt_d;
  logic                mcnt_last;

  always_comb begin
    state_d   = state;
    mcnt_d    = mcnt_q;
    mcnt_last = (mcnt_q == MCNT_W'(MASK_TICKS - 1));
    unique case (state)
      PS_RUN: begin
        if (suspend_req) begin
          state_d = PS_SUSP;
          mcnt_d  = '0;
        end else if (sleep_req) begin
          state_d = PS_SLEEP;
        end
      end
      PS_SLEEP: begin
        if (wake) state_d = PS_RUN;
      end
      PS_SUSP: begin
        if (wake) state_d = PS_MASK;
      end
      PS_MASK: begin
        if (ref_tick) begin
          if (mcnt_last) state_d = PS_RUN;
          else           mcnt_d  = mcnt_q + MCNT_W'(1);
        end
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state  <= PS_RUN;
      mcnt_q <= '0;
    end else begin
      state  <= state_d;
      mcnt_q <= mcnt_d;
    end
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned DIV_W      = 2,
  parameter int unsigned NUM_PLL    = 2,
  parameter int unsigned MASK_TICKS = 3280
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               sleep_req,
  input  logic               suspend_req,
  input  logic               irq,
  input  logic               fiq,
  input  logic               wdt_rst,
  input  logic               ref_tick,
  output logic               bus1_ce,
  output logic               bus2_ce,
  output logic               cpu_ce,
  output logic               rtc_en,
  output logic               usb_en,
  output logic               lcd_en,
  output logic [DIV_W-1:0]   div_sel,
  output logic [NUM_PLL-1:0] pll_pd,
  output logic               pll_mask,
  output logic               sdram_sr_req,
  output logic               mask_busy
);
  import pwr_pkg::*;

  localparam int unsigned PHASE_W = (1 << DIV_W) - 1;

  logic [1:0]         rst_sync_q;
  logic               srst_n;
  logic [DIV_W-1:0]   target_div;
  logic [PHASE_W-1:0] phase;
  logic               bus_ce;
  logic               wake;
  pwr_state_e         state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign srst_n = rst_sync_q[1];

  assign wake = irq | fiq | wdt_rst;

  pwr_speed_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .DIV_W(DIV_W)
  ) u_speed (
    .clk(clk), .srst_n(srst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wdt_rst(wdt_rst), .target_div(target_div)
  );

  pwr_div_gen #(
    .DIV_W(DIV_W), .PHASE_W(PHASE_W)
  ) u_div (
    .clk(clk), .srst_n(srst_n), .target_div(target_div),
    .div_sel(div_sel), .phase(phase), .bus_ce(bus_ce)
  );

  pwr_fsm #(
    .MASK_TICKS(MASK_TICKS)
  ) u_fsm (
    .clk(clk), .srst_n(srst_n), .sleep_req(sleep_req),
    .suspend_req(suspend_req), .wake(wake), .ref_tick(ref_tick),
    .state(state)
  );

  always_comb begin
    rtc_en       = 1'b1;
    bus1_ce      = 1'b0;
    bus2_ce      = 1'b0;
    cpu_ce       = 1'b0;
    usb_en       = 1'b0;
    lcd_en       = 1'b0;
    pll_pd       = '0;
    pll_mask     = 1'b0;
    mask_busy    = 1'b0;
    sdram_sr_req = 1'b1;
    unique case (state)
      PS_RUN: begin
        bus1_ce      = bus_ce;
        bus2_ce      = bus_ce;
        cpu_ce       = bus_ce;
        usb_en       = 1'b1;
        lcd_en       = 1'b1;
        sdram_sr_req = 1'b0;
      end
      PS_SLEEP: begin
        bus2_ce = bus_ce;
        usb_en  = 1'b1;
        lcd_en  = 1'b1;
      end
      PS_SUSP: begin
        pll_pd   = {NUM_PLL{1'b1}};
        pll_mask = 1'b1;
      end
      PS_MASK: begin
        pll_mask  = 1'b1;
        mask_busy = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk #(
  parameter int unsigned DIV_W   = 2,
  parameter int unsigned PHASE_W = 3,
  parameter int unsigned NUM_PLL = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sleep_req,
  input logic               suspend_req,
  input logic [DIV_W-1:0]   div_sel,
  input logic [PHASE_W-1:0] phase,
  input logic               bus1_ce,
  input logic               bus2_ce,
  input logic               cpu_ce,
  input logic               usb_en,
  input logic [NUM_PLL-1:0] pll_pd,
  input logic               pll_mask,
  input logic               mask_busy,
  input logic               sdram_sr_req
);
  // R3
  div_wrap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel != $past(div_sel)) |-> ($past(phase) == '1));

  // R5
  pd_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pll_pd) |-> (!cpu_ce && !bus2_ce && !usb_en && pll_mask));

  // R7
  busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_busy |-> (pll_mask && (pll_pd == '0) && !bus1_ce && !bus2_ce));

  // R4
  cpu_needs_bus1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> bus1_ce);

  // R6
  sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdram_sr_req) |-> $past(sleep_req || suspend_req));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mask_busy) |-> !pll_mask);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(
  .DIV_W(DIV_W), .PHASE_W(PHASE_W), .NUM_PLL(NUM_PLL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .suspend_req(suspend_req),
  .div_sel(div_sel), .phase(phase), .bus1_ce(bus1_ce), .bus2_ce(bus2_ce),
  .cpu_ce(cpu_ce), .usb_en(usb_en), .pll_pd(pll_pd), .pll_mask(pll_mask),
  .mask_busy(mask_busy), .sdram_sr_req(sdram_sr_req)
);

// File: tb/pwr_state_ctrl_tb_top.sv
module pwr_state_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MT = 3280;
  localparam int WDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sleep_req = 1'b0, suspend_req = 1'b0;
  logic       irq = 1'b0, fiq = 1'b0, wdt_rst = 1'b0, ref_tick = 1'b0;
  logic       bus1_ce, bus2_ce, cpu_ce, rtc_en, usb_en, lcd_en;
  logic [1:0] div_sel, pll_pd;
  logic       pll_mask, sdram_sr_req, mask_busy;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctrl #(.MASK_TICKS(MT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sleep_req(sleep_req), .suspend_req(suspend_req),
    .irq(irq), .fiq(fiq), .wdt_rst(wdt_rst), .ref_tick(ref_tick),
    .bus1_ce(bus1_ce), .bus2_ce(bus2_ce), .cpu_ce(cpu_ce), .rtc_en(rtc_en),
    .usb_en(usb_en), .lcd_en(lcd_en), .div_sel(div_sel), .pll_pd(pll_pd),
    .pll_mask(pll_mask), .sdram_sr_req(sdram_sr_req), .mask_busy(mask_busy)
  );

  // behavioural reference: 0 run, 1 light, 2 deep, 3 settling
  int m_st = 0, m_sel = 3, m_div = 3, m_ph = 0, m_tk = 0, m_rs = 0;
  bit m_valid = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int n_sel, n_div, n_st, n_tk, tgt;
    bit wake;
    m_valid = 1;
    if (!rst_n) begin
      m_rs = 0; m_st = 0; m_sel = 3; m_div = 3; m_ph = 0; m_tk = 0;
    end else if (m_rs < 2) begin
      m_rs++; m_st = 0; m_sel = 3; m_div = 3; m_ph = 0; m_tk = 0;
    end else begin
      wake = irq || fiq || wdt_rst;
      n_sel = m_sel;
      if (wdt_rst) n_sel = 3;
      else if (wr_en && wr_addr == 0) n_sel = wr_data[2:0];
      tgt = (m_sel > 3) ? 3 : m_sel;
      n_div = (m_ph == 7) ? tgt : m_div;
      n_st = m_st; n_tk = m_tk;
      case (m_st)
        0: if (suspend_req) begin n_st = 2; n_tk = 0; end
           else if (sleep_req) n_st = 1;
        1: if (wake) n_st = 0;
        2: if (wake) n_st = 3;
        default: if (ref_tick) begin
          if (m_tk == MT-1) n_st = 0; else n_tk = m_tk + 1;
        end
      endcase
      m_sel = n_sel; m_div = n_div; m_st = n_st; m_tk = n_tk;
      m_ph = (m_ph + 1) % 8;
    end
  end

  always @(negedge clk) begin
    int msk;
    bit ce;
    if (m_valid && !done) begin
      msk = (1 << m_div) - 1;
      ce = ((m_ph & msk) == msk);
      chk("R3 div_sel", div_sel, m_div);
      chk("R1 rtc_en", rtc_en, 1);
      chk("R3 bus2_ce", bus2_ce, (m_st <= 1) ? ce : 0);
      chk("R4 bus1_ce", bus1_ce, (m_st == 0) ? ce : 0);
      chk("R4 cpu_ce", cpu_ce, (m_st == 0) ? ce : 0);
      chk("R4 usb_en", usb_en, (m_st <= 1) ? 1 : 0);
      chk("R4 lcd_en", lcd_en, (m_st <= 1) ? 1 : 0);
      chk("R4 sdram_sr_req", sdram_sr_req, (m_st != 0) ? 1 : 0);
      chk("R5 pll_pd", pll_pd, (m_st == 2) ? 3 : 0);
      chk("R7 pll_mask", pll_mask, (m_st >= 2) ? 1 : 0);
      chk("R7 mask_busy", mask_busy, (m_st == 3) ? 1 : 0);
    end
  end

  // periodic reference tick, one cycle in four
  always begin
    @(posedge clk); #1;
    ref_tick = ((cyc % 4) == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic pulse(ref logic s);
    @(posedge clk); #1; s = 1;
    @(posedge clk); #1; s = 0;
  endtask

  task automatic wait_release();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!mask_busy) break;
    end
  endtask

  initial begin
    idle(4);
    rst_n = 1;
    idle(4);
    @(negedge clk); chk("R1 div after reset", div_sel, 3);
    chk("R1 run after reset", sdram_sr_req, 0);

    wr(0, 8'h00); idle(10); @(negedge clk); chk("R2 code0", div_sel, 0);
    wr(0, 8'h01); idle(10); @(negedge clk); chk("R2 code1", div_sel, 1);
    wr(0, 8'hF2); idle(10); @(negedge clk); chk("R2 code2", div_sel, 2);
    wr(0, 8'h05); idle(10); @(negedge clk); chk("R2 code5", div_sel, 3);
    wr(4'h1, 8'h00); idle(10); @(negedge clk); chk("R2 other addr", div_sel, 3);
    wr(0, 8'h00); idle(10);

    pulse(irq); idle(3); @(negedge clk); chk("R9 irq in run", sdram_sr_req, 0);

    pulse(sleep_req); idle(2); @(negedge clk);
    chk("R4 light bus1", bus1_ce, 0); chk("R4 light bus2", bus2_ce, 1);
    pulse(suspend_req); idle(2); @(negedge clk); chk("R9 deep in light", pll_pd, 0);
    pulse(irq); idle(2); @(negedge clk);
    chk("R6 irq wakes light", sdram_sr_req, 0);
    chk("R8 speed kept", div_sel, 0);

    wr(0, 8'h02); idle(10);
    @(posedge clk); #1; sleep_req = 1; suspend_req = 1;
    @(posedge clk); #1; sleep_req = 0; suspend_req = 0;
    idle(2); @(negedge clk); chk("R5 deep priority", pll_pd, 3);
    pulse(fiq); idle(2); @(negedge clk); chk("R6 fiq to settle", mask_busy, 1);
    chk("R7 pll on while masked", pll_pd, 0);
    wait_release(); idle(1); @(negedge clk);
    chk("R7 released", pll_mask, 0);
    chk("R8 speed kept after deep", div_sel, 2);

    pulse(suspend_req); idle(20);
    pulse(wdt_rst); idle(40); @(negedge clk);
    chk("R7 count restarts", mask_busy, 1);
    wait_release(); idle(10); @(negedge clk);
    chk("R8 watchdog forces slow", div_sel, 3);

    wr(0, 8'h00); idle(10);
    @(posedge clk); #1; wr_en = 1; wr_addr = 0; wr_data = 8'h01; wdt_rst = 1;
    @(posedge clk); #1; wr_en = 0; wdt_rst = 0;
    idle(10); @(negedge clk); chk("R8 watchdog beats write", div_sel, 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule